// File: doc/BRIEF.md
# Masked-Write GPIO Bank

This block is one 32-pin general-purpose I/O bank on a simple memory-mapped register bus. Software sets output levels through two half-word update registers. Each write to one of them carries a 16-bit mask in its upper half and 16 data bits in its lower half. Only the pins whose mask bit is clear take the new data, so any subset of pins changes in a single bus write. No read-modify-write is needed, and two agents sharing the bank cannot overwrite each other's pins.

Each pin also has a direction bit and an output-enable bit. A pin is driven only when both of its bits are 1. The live pin levels pass through a two-stage synchronizer and can be read back from their own register. Writes take effect on the clock edge that samples the write strobe. Read data appears one cycle after the read strobe.

Top module: `gpio_mask_bank`

## Requirements
- R1: A synchronous active-high reset clears the output data, direction and output-enable registers. After reset, `pin_out` is 0, `pin_oe` is 0, `bus_rdata` is 0, and a read of 0x204 or 0x208 returns 0.
- R2: A write to offset 0x000 updates output pin i (i = 0..15) to `bus_wdata[i]` when the mask bit `bus_wdata[16+i]` is 0. The new value shows on `pin_out` right after the clock edge that samples the strobe.
- R3: During a masked write, a pin whose mask bit is 1 keeps its previous output value. With no write at all, `pin_out` and `pin_oe` hold.
- R4: A write to offset 0x004 updates output pin 16+n from `bus_wdata[n]` when `bus_wdata[16+n]` is 0 (n = 0..15). Pins 0..15 are not affected.
- R5: Offset 0x204 is the direction register, 1 = output and 0 = input. A write replaces all 32 bits, and a read returns them.
- R6: Offset 0x208 is the output-enable register, readable and writable as a full word. `pin_oe[i]` is 1 only when direction bit i and output-enable bit i are both 1.
- R7: A read of offset 0x060 returns the synchronized pin levels. A level on `pin_in` that is present before clock edge k is returned by a read whose strobe is sampled at edge k+2 or later, and not by a read sampled at edge k or k+1.
- R8: A read of the write-only offsets 0x000 and 0x004, or of any unmapped offset, returns 0.
- R9: `bus_rdata` carries the value of the register selected by a read strobe in the cycle after that strobe. It is 0 in any cycle that follows a cycle without a read strobe. A read and a write in the same cycle return the value from before the write.
- R10: Writes to the read-only offset 0x060 or to unmapped offsets change neither `pin_out` nor `pin_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_addr | input | 12 | Byte offset within the bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after `bus_rd` |
| pin_in | input | 32 | Raw pin levels from the pads |
| pin_out | output | 32 | Output level for each pin |
| pin_oe | output | 32 | Drive enable for each pin |

## Verification
Most internal state of this bank drives a port directly, so errors show up quickly. A wrong output-data bit appears on `pin_out` in the cycle after the offending write. A wrong direction or enable bit appears on `pin_oe` in that same cycle. A fault in the synchronizer depth shows up as a readback that arrives one edge early or late. A decode error shows up as a register that changes when it should not, or as nonzero data read from a write-only offset. The bench keeps a reference model that is updated on every edge and compares all three outputs against it every cycle. Directed sequences then target the mask polarity, the half-word mapping and the exact readback latency.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int ADDR_W  = 12;
    localparam int HALF_W  = 16;
    localparam int HALVES  = 2;
    localparam int PINS    = HALF_W * HALVES;
    localparam int SYNC_N  = 2;

    localparam logic [ADDR_W-1:0] OFS_LOW   = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_HIGH  = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_LEVEL = 12'h060;
    localparam logic [ADDR_W-1:0] OFS_DIR   = 12'h204;
    localparam logic [ADDR_W-1:0] OFS_OEN   = 12'h208;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_LOW,
        SEL_HIGH,
        SEL_LEVEL,
        SEL_DIR,
        SEL_OEN
    } reg_sel_e;

    typedef struct packed {
        logic [HALF_W-1:0] keep;
        logic [HALF_W-1:0] value;
    } masked_word_t;

    typedef struct packed {
        logic [PINS-1:0] dir;
        logic [PINS-1:0] oen;
    } ctrl_regs_t;

    function automatic reg_sel_e decode_offset(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_LOW:   return SEL_LOW;
            OFS_HIGH:  return SEL_HIGH;
            OFS_LEVEL: return SEL_LEVEL;
            OFS_DIR:   return SEL_DIR;
            OFS_OEN:   return SEL_OEN;
            default:   return SEL_NONE;
        endcase
    endfunction

    // Bits whose keep flag is set retain the old value.
    function automatic logic [HALF_W-1:0] merge_half(
        input logic [HALF_W-1:0] old_v,
        input masked_word_t      w
    );
        return (old_v & w.keep) | (w.value & ~w.keep);
    endfunction

    function automatic reg_sel_e half_select(input int idx);
        return (idx == 0) ? SEL_LOW : SEL_HIGH;
    endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_bank_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    always_comb begin
        sel = decode_offset(addr);
    end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] synced
);
    logic [WIDTH-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= raw;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign synced = chain[STAGES-1];
endmodule

// File: rtl/gpio_masked_out.sv
module gpio_masked_out
    import gpio_bank_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr,
    input  reg_sel_e        sel,
    input  masked_word_t    word,
    output logic [PINS-1:0] out_q
);
    genvar h;
    generate
        for (h = 0; h < HALVES; h++) begin : g_half
            localparam int LO = h * HALF_W;
            logic hit;
            assign hit = wr && (sel == half_select(h));
            always_ff @(posedge clk) begin
                if (rst)
                    out_q[LO +: HALF_W] <= '0;
                else if (hit)
                    out_q[LO +: HALF_W] <= merge_half(out_q[LO +: HALF_W], word);
            end
        end
    endgenerate
endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
    import gpio_bank_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr,
    input  reg_sel_e        sel,
    input  logic [PINS-1:0] wdata,
    output ctrl_regs_t      regs
);
    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else if (wr) begin
            if (sel == SEL_DIR) regs.dir <= wdata;
            if (sel == SEL_OEN) regs.oen <= wdata;
        end
    end
endmodule

// File: rtl/gpio_mask_bank.sv
module gpio_mask_bank
    import gpio_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PINS-1:0]   bus_wdata,
    output logic [PINS-1:0]   bus_rdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe
);
    reg_sel_e        sel;
    ctrl_regs_t      ctrl;
    logic [PINS-1:0] level;
    logic [PINS-1:0] rd_next;
    masked_word_t    mword;

    assign mword = masked_word_t'(bus_wdata);

    gpio_addr_decode u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    gpio_masked_out u_out (
        .clk   (clk),
        .rst   (rst),
        .wr    (bus_wr),
        .sel   (sel),
        .word  (mword),
        .out_q (pin_out)
    );

    gpio_ctrl_regs u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .wr    (bus_wr),
        .sel   (sel),
        .wdata (bus_wdata),
        .regs  (ctrl)
    );

    gpio_in_sync #(.WIDTH(PINS), .STAGES(SYNC_N)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw    (pin_in),
        .synced (level)
    );

    assign pin_oe = ctrl.dir & ctrl.oen;

    always_comb begin
        case (sel)
            SEL_LEVEL: rd_next = level;
            SEL_DIR:   rd_next = ctrl.dir;
            SEL_OEN:   rd_next = ctrl.oen;
            default:   rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_next;
        else             bus_rdata <= '0;
    end
endmodule

// File: rtl/gpio_mask_bank_checks.sv
module gpio_mask_bank_checks
    import gpio_bank_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [PINS-1:0]   bus_wdata,
    input logic [PINS-1:0]   bus_rdata,
    input logic [PINS-1:0]   pin_out,
    input logic [PINS-1:0]   pin_oe
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (pin_out == '0 && pin_oe == '0 && bus_rdata == '0));

    assert_low_update_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_LOW) |=>
        pin_out[15:0] == (($past(pin_out[15:0]) & $past(bus_wdata[31:16]))
                        | ($past(bus_wdata[15:0]) & ~$past(bus_wdata[31:16]))));

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> ($stable(pin_out) && $stable(pin_oe)));

    assert_high_spares_low_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_HIGH) |=> $stable(pin_out[15:0]));

    assert_wo_reads_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && (bus_addr == OFS_LOW || bus_addr == OFS_HIGH)) |=> bus_rdata == '0);

    assert_rdata_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> bus_rdata == '0);

    assert_ro_write_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_LEVEL) |=> ($stable(pin_out) && $stable(pin_oe)));
endmodule

bind gpio_mask_bank gpio_mask_bank_checks u_checks (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/gpio_mask_bank_test.sv
module gpio_mask_bank_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst = 1;
    logic        bus_wr = 0;
    logic        bus_rd = 0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;

    int checks = 0;
    int errors = 0;
    bit started = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_mask_bank uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // Behavioural reference model
    logic [31:0] m_out, m_dir, m_oen, m_s1, m_s2, m_rd;
    always @(posedge clk) begin
        logic [31:0] nrd;
        started = 1;
        if (rst) begin
            m_out = 0; m_dir = 0; m_oen = 0; m_s1 = 0; m_s2 = 0; m_rd = 0;
        end else begin
            nrd = 0;
            if (bus_rd) begin
                if (bus_addr == 12'h060) nrd = m_s2;
                else if (bus_addr == 12'h204) nrd = m_dir;
                else if (bus_addr == 12'h208) nrd = m_oen;
            end
            if (bus_wr) begin
                if (bus_addr == 12'h000 || bus_addr == 12'h004) begin
                    for (int i = 0; i < 16; i++) begin
                        if (!bus_wdata[16+i]) begin
                            if (bus_addr == 12'h000) m_out[i] = bus_wdata[i];
                            else m_out[16+i] = bus_wdata[i];
                        end
                    end
                end
                if (bus_addr == 12'h204) m_dir = bus_wdata;
                if (bus_addr == 12'h208) m_oen = bus_wdata;
            end
            m_s2 = m_s1;
            m_s1 = pin_in;
            m_rd = nrd;
        end
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            check("R2 model pin_out", pin_out, m_out);
            check("R6 model pin_oe", pin_oe, m_dir & m_oen);
            check("R9 model bus_rdata", bus_rdata, m_rd);
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0; bus_wdata = 0;
    endtask

    task automatic rd(input logic [11:0] a);
        bus_rd = 1; bus_addr = a;
        @(negedge clk);
        bus_rd = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 pin_out reset", pin_out, 32'h0);
        check("R1 pin_oe reset", pin_oe, 32'h0);
        rst = 0;
        rd(12'h204); check("R1 dir reset read", bus_rdata, 32'h0);
        rd(12'h208); check("R1 oen reset read", bus_rdata, 32'h0);

        wr(12'h208, 32'hFFFF_FFFF);
        check("R6 oen alone does not drive", pin_oe, 32'h0);
        wr(12'h204, 32'h0000_FFFF);
        check("R6 pin_oe dir and oen", pin_oe, 32'h0000_FFFF);
        rd(12'h204); check("R5 dir readback", bus_rdata, 32'h0000_FFFF);
        rd(12'h208); check("R6 oen readback", bus_rdata, 32'hFFFF_FFFF);

        wr(12'h000, 32'h0000_A5A5);
        check("R2 low write", pin_out, 32'h0000_A5A5);
        wr(12'h000, 32'hFF00_0000);
        check("R3 masked upper byte kept", pin_out, 32'h0000_A500);
        wr(12'h004, 32'h0000_1234);
        check("R4 high write maps n to n+16", pin_out, 32'h1234_A500);
        wr(12'h004, 32'hFFFF_FFFF);
        check("R3 fully masked high write", pin_out, 32'h1234_A500);
        wr(12'h004, 32'hFFFE_0001);
        check("R4 single pin 16", pin_out, 32'h1235_A500);

        wr(12'h060, 32'h0000_0000);
        check("R10 write to level offset pins", pin_out, 32'h1235_A500);
        wr(12'h100, 32'h0000_0000);
        check("R10 unmapped write pins", pin_out, 32'h1235_A500);
        check("R10 unmapped write oe", pin_oe, 32'h0000_FFFF);

        // Same-cycle read and write returns pre-write value
        bus_wr = 1; bus_rd = 1; bus_addr = 12'h204; bus_wdata = 32'hF0F0_0000;
        @(negedge clk);
        bus_wr = 0; bus_rd = 0;
        check("R9 read during write sees old", bus_rdata, 32'h0000_FFFF);
        check("R5 dir write applied", pin_oe, 32'hF0F0_0000);

        // Synchronizer latency
        pin_in = 32'hDEAD_BEEF;
        rd(12'h060); check("R7 read at edge k", bus_rdata, 32'h0);
        rd(12'h060); check("R7 read at edge k+1", bus_rdata, 32'h0);
        rd(12'h060); check("R7 read at edge k+2", bus_rdata, 32'hDEAD_BEEF);
        pin_in = 32'h0F0F_1234;
        @(negedge clk);
        @(negedge clk);
        rd(12'h060); check("R7 second pattern", bus_rdata, 32'h0F0F_1234);

        rd(12'h000); check("R8 low word reads zero", bus_rdata, 32'h0);
        rd(12'h004); check("R8 high word reads zero", bus_rdata, 32'h0);
        rd(12'h300); check("R8 unmapped reads zero", bus_rdata, 32'h0);
        @(negedge clk);
        check("R9 no strobe gives zero", bus_rdata, 32'h0);

        rst = 1;
        @(negedge clk);
        rst = 0;
        check("R1 mid-run reset pins", pin_out, 32'h0);
        check("R1 mid-run reset oe", pin_oe, 32'h0);
        repeat (2) @(negedge clk);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule